// File: doc/BRIEF.md
# Translation Unit Control and Fault Register Block

This block is the software-visible face of an address translation unit. A processor reaches it through a plain 32-bit register port with a write strobe, a read strobe and a byte offset. Through that port software turns translation on and off, asks the unit to stop and waits for the stop to be confirmed, programs a replacement/quality-of-service configuration and the page-table base, and asks for the translation cache to be invalidated, either whole or one 4 KiB page at a time.

The translation datapath reports faults to the block as a strobe, a 3-bit type code and the faulting address. Each accepted fault sets its own interrupt status bit, stores the address in one of four capture registers chosen by the kind of fault, and stops the unit at once. The unit stays stopped until software writes the run value to the control register again. The interrupt line is high whenever any status bit is set. Software clears status bits by writing ones to a clear register.

Reads return data one cycle after the read strobe. The version register is read-only and is fixed by a parameter.

Top module: `xlat_ctl_regs`

## Requirements
- R1: After reset, control, status, interrupt status, the capture registers, configuration and page-table base all read 0, the interrupt line is low, and the version register reads VERSION in bits [31:21] and 0 below them (0x30600000 by default).
- R2: Writing 0x5 to control (offset 0x00) makes the unit run, and control then reads 0x5. Writing 0x0 turns it off, and control then reads 0x0. Writing any other value except 0x7 leaves the state unchanged.
- R3: Writing 0x7 to control makes control read 0x7 and asks the unit to stop. Status bit 0 (offset 0x08) goes to 1 on the first clock edge at which the busy input is low, and stays 0 for as long as busy is high.
- R4: A fault strobe that arrives while the unit is off is ignored. No status bit is set, no address is captured and the unit is not stopped.
- R5: An accepted fault puts the unit in the stopped state on the next edge: status bit 0 reads 1 and control reads 0x7. The unit leaves that state only on a write of 0x5. When a fault and a control write fall on the same edge, the fault wins.
- R6: An accepted fault of type code t sets bit t of the interrupt status register (offset 0x18). The codes are 0 page fault, 1 read multi-hit, 2 write multi-hit, 3 bus error, 4 read security, 5 read access, 6 write security and 7 write protection. The interrupt line is the OR of all status bits.
- R7: Writing a mask to the clear register (offset 0x1C) clears every status bit that has a 1 in the mask. A fault that sets a bit on the same edge as a clear of that bit leaves the bit set.
- R8: The fault address is captured by kind of fault. Page faults go to 0x24. Codes 2, 6 and 7 go to 0x28. Codes 1, 4 and 5 go to 0x2C. Bus errors go to 0x30. A later fault of the same kind overwrites the captured value.
- R9: A write to 0x0C with bit 0 set gives a one-cycle pulse on inv_all in the cycle after the write. With bit 0 clear, the write gives no pulse.
- R10: A write to 0x10 with bit 0 set gives a one-cycle inv_entry pulse in the cycle after the write, with inv_page equal to write data bits [31:12]. With bit 0 clear, the write gives no pulse.
- R11: Configuration (offset 0x04) keeps only the bits under mask 0x0150FFFF and drives them on cfg. Bit 0 selects LRU replacement and bits [10:7] hold the QoS value. The page-table base (offset 0x14) stores all 32 bits and drives pt_base.
- R12: Writes to the version register have no effect. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| xl_busy | input | 1 | Datapath has a transaction in flight |
| flt_valid | input | 1 | Fault strobe from the datapath |
| flt_type | input | 3 | Fault type code |
| flt_addr | input | 32 | Faulting address |
| xl_enable | output | 1 | Translation is switched on |
| xl_hold | output | 1 | Datapath must stop taking new requests |
| irq | output | 1 | Interrupt, OR of the status bits |
| cfg | output | 32 | Masked configuration word |
| pt_base | output | 32 | Page-table base address |
| inv_all | output | 1 | Pulse: invalidate the whole cache |
| inv_entry | output | 1 | Pulse: invalidate one page |
| inv_page | output | 20 | Page number for inv_entry |

## Verification
The fault input and the register port can act on the same status bit, and on the control state, in the same clock edge. The bench provokes this from one falling edge. It first raises a fault of one type together with a clear write whose mask covers that type and a second, already set type, then repeats with a run write to control in place of the clear. A correct design leaves only the new fault's bit set in the first case and keeps status bit 0 at 1 in the second. A clear that wins, or a write that releases the stop, shows up in the read value that follows.

// File: rtl/xlat_regs_pkg.sv
`timescale 1ns/1ps
package xlat_regs_pkg;

  localparam int FLT_TYPES = 8;
  localparam int FLT_TW    = 3;
  localparam int SINKS     = 4;

  localparam logic [7:0] OFS_CTL      = 8'h00;
  localparam logic [7:0] OFS_CFG      = 8'h04;
  localparam logic [7:0] OFS_STAT     = 8'h08;
  localparam logic [7:0] OFS_INV_ALL  = 8'h0C;
  localparam logic [7:0] OFS_INV_ONE  = 8'h10;
  localparam logic [7:0] OFS_PTBASE   = 8'h14;
  localparam logic [7:0] OFS_ISTAT    = 8'h18;
  localparam logic [7:0] OFS_ICLR     = 8'h1C;
  localparam logic [7:0] OFS_PF_ADDR  = 8'h24;
  localparam logic [7:0] OFS_WR_ADDR  = 8'h28;
  localparam logic [7:0] OFS_RD_ADDR  = 8'h2C;
  localparam logic [7:0] OFS_BUS_ADDR = 8'h30;
  localparam logic [7:0] OFS_VER      = 8'h34;

  localparam logic [31:0] CMD_OFF  = 32'h0;
  localparam logic [31:0] CMD_RUN  = 32'h5;
  localparam logic [31:0] CMD_HOLD = 32'h7;

  localparam logic [31:0] CFG_WMASK = 32'h0150_FFFF;

  typedef enum logic [1:0] {ST_OFF, ST_RUN, ST_WAIT, ST_HALT} ctl_state_e;

  // Index order of the address capture registers
  typedef enum logic [1:0] {SINK_PAGE, SINK_READ, SINK_WRITE, SINK_BUS} sink_e;

  function automatic sink_e sink_of(input logic [FLT_TW-1:0] code);
    case (code)
      3'd0:                sink_of = SINK_PAGE;
      3'd1, 3'd4, 3'd5:    sink_of = SINK_READ;
      3'd3:                sink_of = SINK_BUS;
      default:             sink_of = SINK_WRITE;
    endcase
  endfunction

endpackage

// File: rtl/xlat_ctl_fsm.sv
`timescale 1ns/1ps
module xlat_ctl_fsm
  import xlat_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_wr_i,
  input  logic [31:0] ctl_wdata_i,
  input  logic        fault_i,
  input  logic        busy_i,
  output ctl_state_e  st_o
);

  ctl_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (fault_i && st_q != ST_OFF) begin
      st_d = ST_HALT;                      // a fault beats any write
    end else if (ctl_wr_i) begin
      case (ctl_wdata_i)
        CMD_RUN:  st_d = ST_RUN;
        CMD_OFF:  st_d = ST_OFF;
        CMD_HOLD: st_d = (st_q == ST_HALT) ? ST_HALT : ST_WAIT;
        default:  st_d = st_q;
      endcase
    end else if (st_q == ST_WAIT && !busy_i) begin
      st_d = ST_HALT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_OFF;
    else     st_q <= st_d;
  end

  assign st_o = st_q;

  AST_WAIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT && busy_i && !fault_i && !ctl_wr_i) |=> (st_q == ST_WAIT)); // R3
  AST_ACK_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT && !busy_i && !fault_i && !ctl_wr_i) |=> (st_q == ST_HALT)); // R3
  AST_FAULT_HALTS: assert property (@(posedge clk) disable iff (rst)
    (fault_i && st_q != ST_OFF) |=> (st_q == ST_HALT)); // R5
  AST_OFF_STAYS: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_OFF && !ctl_wr_i) |=> (st_q == ST_OFF)); // R4

endmodule

// File: rtl/xlat_fault_log.sv
`timescale 1ns/1ps
module xlat_fault_log
  import xlat_regs_pkg::*;
#(
  parameter int AW = 32
)(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      acc_i,
  input  logic [FLT_TW-1:0]         type_i,
  input  logic [AW-1:0]             addr_i,
  input  logic                      clr_wr_i,
  input  logic [FLT_TYPES-1:0]      clr_mask_i,
  output logic [FLT_TYPES-1:0]      stat_o,
  output logic [SINKS-1:0][AW-1:0]  sink_addr_o
);

  // One sticky bit per fault type; a set on the same edge beats a clear
  for (genvar i = 0; i < FLT_TYPES; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)                                        bit_q <= 1'b0;
      else if (acc_i && type_i == FLT_TW'(i))         bit_q <= 1'b1;
      else if (clr_wr_i && clr_mask_i[i])             bit_q <= 1'b0;
    end
    assign stat_o[i] = bit_q;
  end

  // One capture register per fault kind
  for (genvar s = 0; s < SINKS; s++) begin : g_sink
    logic [AW-1:0] a_q;
    always_ff @(posedge clk) begin
      if (rst)                                        a_q <= '0;
      else if (acc_i && sink_of(type_i) == sink_e'(s)) a_q <= addr_i;
    end
    assign sink_addr_o[s] = a_q;
  end

  AST_TYPE_SETS_BIT: assert property (@(posedge clk) disable iff (rst)
    acc_i |=> stat_o[$past(type_i)]); // R6
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (clr_wr_i && !acc_i) |=> ((stat_o & $past(clr_mask_i)) == '0)); // R7
  AST_READ_SINK: assert property (@(posedge clk) disable iff (rst)
    (acc_i && sink_of(type_i) == SINK_READ) |=> (sink_addr_o[SINK_READ] == $past(addr_i))); // R8

endmodule

// File: rtl/xlat_inv_gen.sv
`timescale 1ns/1ps
module xlat_inv_gen #(
  parameter int PW = 20
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          all_wr_i,
  input  logic          one_wr_i,
  input  logic          go_bit_i,
  input  logic [PW-1:0] page_i,
  output logic          inv_all_o,
  output logic          inv_one_o,
  output logic [PW-1:0] page_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_all_o <= 1'b0;
      inv_one_o <= 1'b0;
      page_o    <= '0;
    end else begin
      inv_all_o <= all_wr_i && go_bit_i;
      inv_one_o <= one_wr_i && go_bit_i;
      if (one_wr_i && go_bit_i) page_o <= page_i;
    end
  end

  AST_INV_ALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    inv_all_o |-> $past(all_wr_i && go_bit_i)); // R9
  AST_INV_ONE_PAGE: assert property (@(posedge clk) disable iff (rst)
    (one_wr_i && go_bit_i) |=> (inv_one_o && page_o == $past(page_i))); // R10

endmodule

// File: rtl/xlat_ctl_regs.sv
`timescale 1ns/1ps
module xlat_ctl_regs
  import xlat_regs_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter logic [10:0] VERSION    = 11'h183,
  parameter int          PAGE_SHIFT = 12
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              xl_busy,
  input  logic              flt_valid,
  input  logic [2:0]        flt_type,
  input  logic [31:0]       flt_addr,
  output logic              xl_enable,
  output logic              xl_hold,
  output logic              irq,
  output logic [31:0]       cfg,
  output logic [31:0]       pt_base,
  output logic              inv_all,
  output logic              inv_entry,
  output logic [31-PAGE_SHIFT:0] inv_page
);

  localparam int PW = 32 - PAGE_SHIFT;
  localparam logic [31:0] VER_WORD = {VERSION, 21'd0};

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    hit = (a == ADDR_W'(ofs));
  endfunction

  ctl_state_e                   st;
  logic                         flt_acc;
  logic [FLT_TYPES-1:0]         istat;
  logic [SINKS-1:0][31:0]       sink_addr;
  logic [31:0]                  cfg_q, ptb_q, rdata_q;

  assign flt_acc = flt_valid && (st != ST_OFF);

  xlat_ctl_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .ctl_wr_i    (reg_wr && hit(reg_addr, OFS_CTL)),
    .ctl_wdata_i (reg_wdata),
    .fault_i     (flt_acc),
    .busy_i      (xl_busy),
    .st_o        (st)
  );

  xlat_fault_log #(.AW(32)) u_flt (
    .clk         (clk),
    .rst         (rst),
    .acc_i       (flt_acc),
    .type_i      (flt_type),
    .addr_i      (flt_addr),
    .clr_wr_i    (reg_wr && hit(reg_addr, OFS_ICLR)),
    .clr_mask_i  (reg_wdata[FLT_TYPES-1:0]),
    .stat_o      (istat),
    .sink_addr_o (sink_addr)
  );

  xlat_inv_gen #(.PW(PW)) u_inv (
    .clk       (clk),
    .rst       (rst),
    .all_wr_i  (reg_wr && hit(reg_addr, OFS_INV_ALL)),
    .one_wr_i  (reg_wr && hit(reg_addr, OFS_INV_ONE)),
    .go_bit_i  (reg_wdata[0]),
    .page_i    (reg_wdata[31:PAGE_SHIFT]),
    .inv_all_o (inv_all),
    .inv_one_o (inv_entry),
    .page_o    (inv_page)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      ptb_q <= '0;
    end else if (reg_wr) begin
      if (hit(reg_addr, OFS_CFG))    cfg_q <= reg_wdata & CFG_WMASK;
      if (hit(reg_addr, OFS_PTBASE)) ptb_q <= reg_wdata;
    end
  end

  logic [31:0] ctl_view;
  always_comb begin
    case (st)
      ST_OFF:  ctl_view = CMD_OFF;
      ST_RUN:  ctl_view = CMD_RUN;
      default: ctl_view = CMD_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      rdata_q <= '0;
      if (hit(reg_addr, OFS_CTL))      rdata_q <= ctl_view;
      if (hit(reg_addr, OFS_CFG))      rdata_q <= cfg_q;
      if (hit(reg_addr, OFS_STAT))     rdata_q <= {31'd0, st == ST_HALT};
      if (hit(reg_addr, OFS_PTBASE))   rdata_q <= ptb_q;
      if (hit(reg_addr, OFS_ISTAT))    rdata_q <= 32'(istat);
      if (hit(reg_addr, OFS_PF_ADDR))  rdata_q <= sink_addr[SINK_PAGE];
      if (hit(reg_addr, OFS_WR_ADDR))  rdata_q <= sink_addr[SINK_WRITE];
      if (hit(reg_addr, OFS_RD_ADDR))  rdata_q <= sink_addr[SINK_READ];
      if (hit(reg_addr, OFS_BUS_ADDR)) rdata_q <= sink_addr[SINK_BUS];
      if (hit(reg_addr, OFS_VER))      rdata_q <= VER_WORD;
    end
  end

  assign reg_rdata = rdata_q;
  assign cfg       = cfg_q;
  assign pt_base   = ptb_q;
  assign irq       = |istat;
  assign xl_enable = (st != ST_OFF);
  assign xl_hold   = (st == ST_WAIT) || (st == ST_HALT);

  AST_VERSION_FIXED: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && hit(reg_addr, OFS_VER)) |=> (reg_rdata == VER_WORD)); // R12
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    flt_acc |=> irq); // R6

endmodule

// File: tb/xlat_ctl_regs_tb.sv
`timescale 1ns/1ps
module xlat_ctl_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xl_busy = 1'b0, flt_valid = 1'b0;
  logic [2:0]  flt_type = '0;
  logic [31:0] flt_addr = '0;
  logic        xl_enable, xl_hold, irq, inv_all, inv_entry;
  logic [31:0] cfg, pt_base;
  logic [19:0] inv_page;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xlat_ctl_regs dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xl_busy(xl_busy),
    .flt_valid(flt_valid), .flt_type(flt_type), .flt_addr(flt_addr),
    .xl_enable(xl_enable), .xl_hold(xl_hold), .irq(irq), .cfg(cfg),
    .pt_base(pt_base), .inv_all(inv_all), .inv_entry(inv_entry), .inv_page(inv_page)
  );

  // op (1 = read), offset, data, expected read value
  localparam int NROW = 10;
  localparam logic [72:0] TBL [NROW] = '{
    {1'b0, 8'h04, 32'hFFFF_FFFF, 32'h0},
    {1'b1, 8'h04, 32'h0,         32'h0150_FFFF},
    {1'b0, 8'h04, 32'h00AA_0783, 32'h0},
    {1'b1, 8'h04, 32'h0,         32'h0000_0783},
    {1'b0, 8'h14, 32'h8000_4000, 32'h0},
    {1'b1, 8'h14, 32'h0,         32'h8000_4000},
    {1'b0, 8'h34, 32'hFFFF_FFFF, 32'h0},
    {1'b1, 8'h34, 32'h0,         32'h3060_0000},
    {1'b1, 8'h20, 32'h0,         32'h0},
    {1'b1, 8'h3C, 32'h0,         32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic flt(input logic [2:0] t, input logic [31:0] a);
    @(negedge clk); flt_valid = 1'b1; flt_type = t; flt_addr = a;
    @(negedge clk); flt_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h00, v); chk("R1 control", v, 32'h0);
    rd(8'h08, v); chk("R1 status", v, 32'h0);
    rd(8'h18, v); chk("R1 int status", v, 32'h0);
    rd(8'h34, v); chk("R1 version", v, 32'h3060_0000);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    chk("R1 cfg", cfg, 32'h0);

    // R4 fault while off is ignored
    flt(3'd0, 32'h0000_1234);
    rd(8'h18, v); chk("R4 int status", v, 32'h0);
    rd(8'h24, v); chk("R4 capture", v, 32'h0);
    rd(8'h08, v); chk("R4 status", v, 32'h0);

    // R11 R12 table walk
    for (int i = 0; i < NROW; i++) begin
      if (TBL[i][72]) begin
        rd(TBL[i][71:64], v);
        chk($sformatf("R11/R12 row %0d", i), v, TBL[i][31:0]);
      end else begin
        wr(TBL[i][71:64], TBL[i][63:32]);
      end
    end
    chk("R11 cfg port", cfg, 32'h0000_0783);
    chk("R11 pt_base port", pt_base, 32'h8000_4000);

    // R2 run, and an unknown control value is ignored
    wr(8'h00, 32'h5);
    rd(8'h00, v); chk("R2 run readback", v, 32'h5);
    chk("R2 enable", {31'd0, xl_enable}, 32'h1);
    wr(8'h00, 32'h3);
    rd(8'h00, v); chk("R2 unknown ignored", v, 32'h5);

    // R9 flush all
    wr(8'h0C, 32'h1);
    chk("R9 pulse", {31'd0, inv_all}, 32'h1);
    @(negedge clk);
    chk("R9 pulse ends", {31'd0, inv_all}, 32'h0);
    wr(8'h0C, 32'h0);
    chk("R9 no pulse", {31'd0, inv_all}, 32'h0);

    // R10 flush entry
    wr(8'h10, 32'hABCD_E001);
    chk("R10 pulse", {31'd0, inv_entry}, 32'h1);
    chk("R10 page", {12'd0, inv_page}, 32'h000A_BCDE);
    wr(8'h10, 32'h1234_5000);
    chk("R10 no pulse", {31'd0, inv_entry}, 32'h0);

    // R3 stop request waits for idle datapath
    xl_busy = 1'b1;
    wr(8'h00, 32'h7);
    repeat (3) @(negedge clk);
    rd(8'h08, v); chk("R3 not acked while busy", v, 32'h0);
    rd(8'h00, v); chk("R3 control", v, 32'h7);
    xl_busy = 1'b0;
    @(negedge clk);
    rd(8'h08, v); chk("R3 acked", v, 32'h1);
    wr(8'h00, 32'h5);
    rd(8'h08, v); chk("R2 released", v, 32'h0);

    // R5 R6 R8 faults and address routing
    flt(3'd5, 32'hDEAD_0000);
    rd(8'h18, v); chk("R6 read access bit", v, 32'h20);
    chk("R6 irq", {31'd0, irq}, 32'h1);
    rd(8'h2C, v); chk("R8 read capture", v, 32'hDEAD_0000);
    rd(8'h08, v); chk("R5 stopped", v, 32'h1);
    rd(8'h00, v); chk("R5 control", v, 32'h7);
    flt(3'd6, 32'h0BAD_0000);
    flt(3'd3, 32'h0000_0077);
    flt(3'd0, 32'h0000_1000);
    flt(3'd2, 32'h0000_2222);
    rd(8'h18, v); chk("R6 accumulated", v, 32'h6D);
    rd(8'h28, v); chk("R8 write capture", v, 32'h0000_2222);
    rd(8'h30, v); chk("R8 bus capture", v, 32'h0000_0077);
    rd(8'h24, v); chk("R8 page capture", v, 32'h0000_1000);
    wr(8'h00, 32'h7);
    rd(8'h08, v); chk("R5 hold write keeps stop", v, 32'h1);

    // R7 clear
    wr(8'h1C, 32'hFF);
    rd(8'h18, v); chk("R7 cleared", v, 32'h0);
    chk("R7 irq low", {31'd0, irq}, 32'h0);
    rd(8'h08, v); chk("R5 still stopped", v, 32'h1);
    wr(8'h00, 32'h5);
    rd(8'h08, v); chk("R5 released", v, 32'h0);

    // R7 fault and clear on the same edge
    flt(3'd1, 32'h0000_0001);
    @(negedge clk);
    flt_valid = 1'b1; flt_type = 3'd0; flt_addr = 32'h0000_5000;
    reg_wr = 1'b1; reg_addr = 8'h1C; reg_wdata = 32'h03;
    @(negedge clk);
    flt_valid = 1'b0; reg_wr = 1'b0;
    rd(8'h18, v); chk("R7 set beats clear", v, 32'h01);
    wr(8'h1C, 32'h01);
    wr(8'h00, 32'h5);

    // R5 fault and run write on the same edge
    @(negedge clk);
    flt_valid = 1'b1; flt_type = 3'd4; flt_addr = 32'h0000_6000;
    reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h5;
    @(negedge clk);
    flt_valid = 1'b0; reg_wr = 1'b0;
    rd(8'h08, v); chk("R5 fault beats run", v, 32'h1);

    wr(8'h00, 32'h0);
    rd(8'h00, v); chk("R2 off", v, 32'h0);
    rd(8'h08, v); chk("R2 off status", v, 32'h0);

    finish_run();
  end

endmodule